// File: doc/BRIEF.md
# Radix Page Table Walker

This block translates a 64-bit virtual address into a physical page address by walking a radix page table in memory. A requester raises `req` with `req_va`. The walker copies its configuration at that moment: two root directory bases, a shift and an index width for each of the five levels (directories 4 to 1 and the leaf level 0), and a 2-bit entry-size code. It then walks down from the top level and issues one 64-bit read per active level through a valid/ready read port. Only one read is outstanding at a time.

A directory entry with its huge bit set ends the walk early, and that entry becomes the final translation entry. Otherwise the walk finishes with one read at level 0. A one-cycle `done` pulse returns the hit status, a write-permission flag and the physical page address. The walker is meant to serve a debug or miss path where translations come straight from the in-memory tables.

Top module: `ptw_walker`

## Requirements
- R1: The root base is `cfg_root_hi` when `req_va[63]` is 1 and `cfg_root_lo` when it is 0. The root is masked to the low PA_W bits (48 by default).
- R2: An entry address is `base | (idx << ((code+1)*3))`. Here `idx = (va >> shift) & ((1<<width)-1)` for the level being read, and `code` is `cfg_pte_code`.
- R3: Directory levels are visited in the order 4, 3, 2, 1. A level whose width field is 0 is skipped and issues no read. Level 0 is always read unless the walk ended earlier.
- R4: A directory word is masked to PA_W bits. If bit 6 (huge) of that word is clear, its low PG_SHIFT bits (12) are cleared to form the next base. If that base is zero, the walk ends with a miss and no further read is made.
- R5: A masked directory word with bit 6 set ends the walk and is used as the final entry, with the level's shift as the offset shift. Bits 14:13 and bit 6 are cleared. If bit 12 is set, bit 12 is cleared and bit 6 (global) is set.
- R6: A leaf read at level 0 uses the level-0 shift and width, and the raw 64-bit word is the final entry.
- R7: If bit 0 (valid) of the final entry is clear, `hit` is 0. Otherwise `hit` is 1 and `perm_rw` equals bit 1 (dirty).
- R8: On a hit, `pa` is formed in three steps. First, add the entry to `(va & PA mask) & ((1<<last_shift)-1)`. Second, clear bits 63, 62 and 61. Third, clear the low PG_SHIFT bits. On a miss, `pa` and `perm_rw` are 0.
- R9: An idle walker accepts `req` and pulses `ack` for one cycle in the next cycle. A `req` seen while `busy` is high is ignored. `done` is a one-cycle pulse.
- R10: The configuration is sampled when a request is accepted. Changes to the configuration inputs during a walk do not affect its result.
- R11: At most one read is outstanding. Once `mem_rd_valid` is raised, it and `mem_rd_addr` hold until `mem_rd_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Translation request |
| req_va | input | 64 | Virtual address to translate |
| ack | output | 1 | One-cycle pulse after a request is taken |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle result pulse |
| hit | output | 1 | Valid translation found |
| perm_rw | output | 1 | 1 read/write, 0 read-only |
| pa | output | 64 | Physical page address |
| cfg_root_lo | input | 64 | Root base for addresses with bit 63 clear |
| cfg_root_hi | input | 64 | Root base for addresses with bit 63 set |
| cfg_shift | input | 30 | Per-level index shift, level L at bits [6L+5:6L] |
| cfg_width | input | 30 | Per-level index width, level L at bits [6L+5:6L] |
| cfg_pte_code | input | 2 | Entry size code, stride shift (code+1)*3 |
| mem_rd_valid | output | 1 | Read request valid |
| mem_rd_ready | input | 1 | Read request accepted |
| mem_rd_addr | output | 64 | Read byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data |

## Verification
The hardest situations to reach from the ports are walks that stop in the middle: a huge entry at an intermediate level, and a directory word that becomes zero only after masking, such as a word holding nothing but attribute bits or bits above the physical width. A random table builder allocates directory pages on demand along each virtual address. At each new directory slot it picks a pointer, a huge entry with random global and level bits, or a word that masks to zero. Directed cases pin a huge entry at the top level, a masked-zero directory entry, and an all-widths-zero layout. The bench scrambles the configuration right after `ack`, and it throttles both `mem_rd_ready` and the response delay.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int unsigned PTW_LEVELS = 5;
    localparam int unsigned PTW_SHW    = 6;
    localparam int unsigned PTW_TOP    = PTW_LEVELS - 1;

    localparam int unsigned E_VALID    = 0;
    localparam int unsigned E_DIRTY    = 1;
    localparam int unsigned E_HUGE     = 6;
    localparam int unsigned E_GLOBAL   = 6;
    localparam int unsigned E_HGLOBAL  = 12;
    localparam int unsigned E_LVL_LO   = 13;
    localparam int unsigned E_LVL_HI   = 14;
    localparam int unsigned E_NR       = 61;
    localparam int unsigned E_NX       = 62;
    localparam int unsigned E_RPLV     = 63;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_READ = 2'd2,
        ST_WAIT = 2'd3
    } ptw_state_e;

    typedef logic [PTW_LEVELS-1:0][PTW_SHW-1:0] lvl_field_t;

    typedef struct packed {
        ptw_state_e  st;
        logic [2:0]  lvl;
        logic [63:0] va;
        logic [63:0] base;
        lvl_field_t  sh;
        lvl_field_t  wd;
        logic [1:0]  code;
        logic        ack;
        logic        done;
        logic        hit;
        logic        rw;
        logic [63:0] pa;
    } ptw_regs_t;

endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr
    import ptw_pkg::*;
(
    input  logic [63:0]        base,
    input  logic [63:0]        va,
    input  logic [PTW_SHW-1:0] shift,
    input  logic [PTW_SHW-1:0] width,
    input  logic [1:0]         code,
    output logic [63:0]        addr
);
    logic [63:0] idx;
    logic [3:0]  stride;

    always_comb begin
        idx    = (va >> shift) & ((64'd1 << width) - 64'd1);
        stride = 4'(({2'b00, code} + 4'd1) * 4'd3);
        addr   = base | (idx << stride);
    end
endmodule

// File: rtl/ptw_leaf_fmt.sv
module ptw_leaf_fmt
    import ptw_pkg::*;
#(
    parameter int unsigned PA_W     = 48,
    parameter int unsigned PG_SHIFT = 12
) (
    input  logic [63:0]        word,
    input  logic               from_dir,
    input  logic [63:0]        va,
    input  logic [PTW_SHW-1:0] last_shift,
    output logic               hit,
    output logic               rw,
    output logic [63:0]        pa
);
    localparam logic [63:0] PA_MASK = (64'd1 << PA_W) - 64'd1;
    localparam logic [63:0] PG_MASK = ~((64'd1 << PG_SHIFT) - 64'd1);

    logic [63:0] pte;
    logic [63:0] offs;
    logic [63:0] sum;

    always_comb begin
        pte = word;
        if (from_dir) begin
            pte[E_LVL_HI:E_LVL_LO] = 2'b00;
            pte[E_HUGE]            = 1'b0;
            if (pte[E_HGLOBAL]) begin
                pte[E_HGLOBAL] = 1'b0;
                pte[E_GLOBAL]  = 1'b1;
            end
        end
        offs         = (va & PA_MASK) & ((64'd1 << last_shift) - 64'd1);
        sum          = pte + offs;
        sum[E_RPLV]  = 1'b0;
        sum[E_NX]    = 1'b0;
        sum[E_NR]    = 1'b0;
        hit          = pte[E_VALID];
        rw           = pte[E_VALID] & pte[E_DIRTY];
        pa           = pte[E_VALID] ? (sum & PG_MASK) : 64'd0;
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int unsigned PA_W     = 48,
    parameter int unsigned PG_SHIFT = 12,
    parameter int unsigned HALF_BIT = 63
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req,
    input  logic [63:0]                   req_va,
    output logic                          ack,
    output logic                          busy,
    output logic                          done,
    output logic                          hit,
    output logic                          perm_rw,
    output logic [63:0]                   pa,
    input  logic [63:0]                   cfg_root_lo,
    input  logic [63:0]                   cfg_root_hi,
    input  logic [PTW_LEVELS*PTW_SHW-1:0] cfg_shift,
    input  logic [PTW_LEVELS*PTW_SHW-1:0] cfg_width,
    input  logic [1:0]                    cfg_pte_code,
    output logic                          mem_rd_valid,
    input  logic                          mem_rd_ready,
    output logic [63:0]                   mem_rd_addr,
    input  logic                          mem_rsp_valid,
    input  logic [63:0]                   mem_rsp_data
);
    localparam logic [63:0] PA_MASK = (64'd1 << PA_W) - 64'd1;
    localparam logic [63:0] PG_MASK = ~((64'd1 << PG_SHIFT) - 64'd1);

    ptw_regs_t  r_q, r_d;
    lvl_field_t sh_in, wd_in;

    for (genvar l = 0; l < PTW_LEVELS; l++) begin : g_unpack
        assign sh_in[l] = cfg_shift[l*PTW_SHW +: PTW_SHW];
        assign wd_in[l] = cfg_width[l*PTW_SHW +: PTW_SHW];
    end

    logic [PTW_SHW-1:0] cur_sh, cur_wd;
    logic [63:0]        rd_addr;
    logic [63:0]        dir_word;
    logic [63:0]        fmt_word;
    logic [63:0]        next_base;
    logic               fmt_hit, fmt_rw;
    logic [63:0]        fmt_pa;
    logic               at_leaf;

    assign cur_sh  = r_q.sh[r_q.lvl];
    assign cur_wd  = r_q.wd[r_q.lvl];
    assign at_leaf = (r_q.lvl == 3'd0);
    assign dir_word  = mem_rsp_data & PA_MASK;
    assign next_base = dir_word & PG_MASK;
    assign fmt_word  = at_leaf ? mem_rsp_data : dir_word;

    ptw_entry_addr u_addr (
        .base  (r_q.base),
        .va    (r_q.va),
        .shift (cur_sh),
        .width (cur_wd),
        .code  (r_q.code),
        .addr  (rd_addr)
    );

    ptw_leaf_fmt #(.PA_W(PA_W), .PG_SHIFT(PG_SHIFT)) u_fmt (
        .word       (fmt_word),
        .from_dir   (!at_leaf),
        .va         (r_q.va),
        .last_shift (cur_sh),
        .hit        (fmt_hit),
        .rw         (fmt_rw),
        .pa         (fmt_pa)
    );

    always_comb begin
        r_d      = r_q;
        r_d.ack  = 1'b0;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req) begin
                    r_d.ack  = 1'b1;
                    r_d.va   = req_va;
                    r_d.base = (req_va[HALF_BIT] ? cfg_root_hi : cfg_root_lo) & PA_MASK;
                    r_d.sh   = sh_in;
                    r_d.wd   = wd_in;
                    r_d.code = cfg_pte_code;
                    r_d.lvl  = 3'(PTW_TOP);
                    r_d.st   = ST_SCAN;
                end
            end
            ST_SCAN: begin
                if (!at_leaf && cur_wd == '0) begin
                    r_d.lvl = r_q.lvl - 3'd1;
                end else begin
                    r_d.st = ST_READ;
                end
            end
            ST_READ: begin
                if (mem_rd_ready) begin
                    r_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    if (at_leaf || dir_word[E_HUGE]) begin
                        r_d.done = 1'b1;
                        r_d.hit  = fmt_hit;
                        r_d.rw   = fmt_rw;
                        r_d.pa   = fmt_pa;
                        r_d.st   = ST_IDLE;
                    end else if (next_base == 64'd0) begin
                        r_d.done = 1'b1;
                        r_d.hit  = 1'b0;
                        r_d.rw   = 1'b0;
                        r_d.pa   = 64'd0;
                        r_d.st   = ST_IDLE;
                    end else begin
                        r_d.base = next_base;
                        r_d.lvl  = r_q.lvl - 3'd1;
                        r_d.st   = ST_SCAN;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ack          = r_q.ack;
    assign busy         = (r_q.st != ST_IDLE);
    assign done         = r_q.done;
    assign hit          = r_q.hit;
    assign perm_rw      = r_q.rw;
    assign pa           = r_q.pa;
    assign mem_rd_valid = (r_q.st == ST_READ);
    assign mem_rd_addr  = rd_addr;

    // R11: a pending read holds its address until accepted
    a_r11_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

    // R9: done lasts exactly one cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: a request seen while busy is not taken
    a_r9_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        busy && req |=> !ack);

    // R9: a walk starts only together with an acknowledge
    a_r9_start_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ack);

    // R8: a miss reports no address and no write permission
    a_r8_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        done && !hit |-> (pa == 64'd0) && !perm_rw);

    // R11: no new read request while the walker is idle
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_rd_valid);

endmodule

// File: tb/ptw_walker_bench.sv
module ptw_walker_bench;
    import ptw_pkg::*;

    localparam logic [63:0] PAM = (64'd1 << 48) - 64'd1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        req = 1'b0;
    logic [63:0] req_va = '0;
    logic        ack, busy, done, hit, perm_rw;
    logic [63:0] pa;
    logic [63:0] p_lo = '0, p_hi = '0;
    logic [29:0] p_sh = '0, p_wd = '0;
    logic [1:0]  p_code = '0;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b0;
    logic [63:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;

    ptw_walker u_ptw_walker (
        .clk(clk), .rst_n(rst_n), .req(req), .req_va(req_va),
        .ack(ack), .busy(busy), .done(done), .hit(hit), .perm_rw(perm_rw), .pa(pa),
        .cfg_root_lo(p_lo), .cfg_root_hi(p_hi), .cfg_shift(p_sh), .cfg_width(p_wd),
        .cfg_pte_code(p_code),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    logic [63:0] mem [logic [63:0]];
    logic [63:0] s_lo, s_hi, next_tbl;
    logic [4:0][5:0] s_sh, s_wd;
    logic [1:0]  s_code;
    int          n_chk = 0, n_fail = 0;
    int          rd_cnt = 0;
    logic [63:0] first_rd = '0;

    function automatic logic [63:0] mrd(input logic [63:0] a);
        return mem.exists(a) ? mem[a] : 64'd0;
    endfunction

    function automatic logic [63:0] eaddr(input logic [63:0] b, input logic [63:0] va,
                                          input logic [5:0] sh, input logic [5:0] wd,
                                          input logic [1:0] cd);
        logic [63:0] ix;
        ix = (va >> sh) & ((64'd1 << wd) - 64'd1);
        return b | (ix << ((int'(cd) + 1) * 3));
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference walk from the requirements
    task automatic ref_walk(input logic [63:0] va, output bit e_hit, output bit e_rw,
                            output logic [63:0] e_pa, output int e_rd, output logic [63:0] e_first);
        logic [63:0] b, a, w, pte, nb, off;
        bit huge, stop;
        logic [5:0] lsh;
        b = (va[63] ? s_hi : s_lo) & PAM;
        e_rd = 0; e_first = 0; huge = 0; stop = 0; pte = 0; lsh = 0;
        e_hit = 0; e_rw = 0; e_pa = 0;
        for (int l = 4; l >= 1; l--) begin
            if (!stop && !huge && s_wd[l] != 0) begin
                a = eaddr(b, va, s_sh[l], s_wd[l], s_code);
                if (e_rd == 0) e_first = a;
                e_rd++;
                w = mrd(a) & PAM;
                if (w[6]) begin
                    huge = 1; pte = w; lsh = s_sh[l];
                end else begin
                    nb = w & ~64'hFFF;
                    if (nb == 0) stop = 1;
                    b = nb;
                end
            end
        end
        if (stop) return;
        if (!huge) begin
            a = eaddr(b, va, s_sh[0], s_wd[0], s_code);
            if (e_rd == 0) e_first = a;
            e_rd++;
            pte = mrd(a); lsh = s_sh[0];
        end else begin
            pte[14:13] = 0; pte[6] = 0;
            if (pte[12]) begin pte[12] = 0; pte[6] = 1; end
        end
        if (!pte[0]) return;
        e_hit = 1; e_rw = pte[1];
        off = (va & PAM) & ((64'd1 << lsh) - 64'd1);
        e_pa = pte + off;
        e_pa[63:61] = 3'b000;
        e_pa = e_pa & ~64'hFFF;
    endtask

    task automatic new_dir(input logic [63:0] a);
        int r;
        logic [63:0] w;
        r = int'($urandom % 100);
        if (r < 8) begin
            w = {($urandom % 2) == 0 ? 4'h0 : 4'h8, 48'd0, 12'(($urandom % 4096) & 32'hFBF)};
        end else if (r < 22) begin
            w = {$urandom, $urandom} | 64'h40;
            if ($urandom % 10 == 0) w[0] = 1'b0;
        end else begin
            next_tbl = next_tbl + (64'd1 << 22);
            w = next_tbl | 64'(($urandom % 4096) & 32'hFBF);
            if ($urandom % 4 == 0) w[63] = 1'b1;
        end
        mem[a] = w;
    endtask

    task automatic build_path(input logic [63:0] va);
        logic [63:0] b, a, w;
        bit fin;
        b = (va[63] ? s_hi : s_lo) & PAM;
        fin = 0;
        for (int l = 4; l >= 1; l--) begin
            if (!fin && s_wd[l] != 0) begin
                a = eaddr(b, va, s_sh[l], s_wd[l], s_code);
                if (!mem.exists(a)) new_dir(a);
                w = mem[a] & PAM;
                if (w[6] || (w & ~64'hFFF) == 0) fin = 1;
                b = w & ~64'hFFF;
            end
        end
        if (!fin) begin
            a = eaddr(b, va, s_sh[0], s_wd[0], s_code);
            if (!mem.exists(a)) begin
                w = {$urandom, $urandom};
                w[0] = ($urandom % 8) != 0;
                mem[a] = w;
            end
        end
    endtask

    task automatic set_mode(input int m);
        s_sh = '0; s_wd = '0;
        s_sh[0] = 12; s_wd[0] = 9;
        case (m)
            0: begin s_sh[3] = 39; s_wd[3] = 9; s_sh[2] = 30; s_wd[2] = 9; s_sh[1] = 21; s_wd[1] = 9; end
            1: begin s_sh[4] = 48; s_wd[4] = 9; s_sh[3] = 39; s_wd[3] = 9;
                     s_sh[2] = 30; s_wd[2] = 9; s_sh[1] = 21; s_wd[1] = 9; end
            2: begin s_sh[4] = 39; s_wd[4] = 9; s_sh[2] = 30; s_wd[2] = 9; s_sh[1] = 21; end
            default: ;
        endcase
    endtask

    task automatic run_one(input logic [63:0] va, input bit probe);
        bit e_hit, e_rw;
        logic [63:0] e_pa, e_first;
        int e_rd, t;
        build_path(va);
        ref_walk(va, e_hit, e_rw, e_pa, e_rd, e_first);
        p_lo = s_lo; p_hi = s_hi; p_sh = s_sh; p_wd = s_wd; p_code = s_code;
        rd_cnt = 0;
        @(negedge clk);
        req = 1'b1; req_va = va;
        t = 0;
        do begin @(negedge clk); t++; end while (!ack && t < 50);
        chk(ack == 1'b1, "R9 ack after request", 64'(ack), 64'd1);
        req = 1'b0;
        // R10: scramble configuration while walking
        p_lo = {$urandom, $urandom}; p_hi = {$urandom, $urandom};
        p_sh = 30'($urandom); p_wd = 30'($urandom); p_code = 2'($urandom);
        if (probe) begin
            req = 1'b1;
            @(negedge clk);
            req = 1'b0;
            chk(ack == 1'b0, "R9 request while busy ignored", 64'(ack), 64'd0);
        end
        t = 0;
        while (!done && t < 2000) begin @(negedge clk); t++; end
        chk(done == 1'b1, "R9 done within timeout", 64'(done), 64'd1);
        chk(hit == e_hit, "R7 hit status", 64'(hit), 64'(e_hit));
        chk(perm_rw == e_rw, "R7 R8 permission", 64'(perm_rw), 64'(e_rw));
        chk(pa == e_pa, "R8 R5 R10 physical address", pa, e_pa);
        chk(rd_cnt == e_rd, "R3 R4 R6 read count", 64'(rd_cnt), 64'(e_rd));
        chk(first_rd == e_first, "R1 R2 first read address", first_rd, e_first);
        @(negedge clk);
        chk(done == 1'b0, "R9 done is a pulse", 64'(done), 64'd0);
    endtask

    // memory responder: random ready, random response delay
    initial begin
        bit pend;
        int dly;
        logic [63:0] la;
        pend = 0; dly = 0; la = 0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (pend) begin
                mem_rd_ready = 1'b0;
                if (dly == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = mrd(la);
                    pend = 0;
                end else dly--;
            end else begin
                mem_rd_ready = ($urandom % 4) != 0;
                if (mem_rd_ready && mem_rd_valid) begin
                    pend = 1; la = mem_rd_addr; dly = int'($urandom % 3);
                    if (rd_cnt == 0) first_rd = mem_rd_addr;
                    rd_cnt++;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [63:0] va, a;
        void'($urandom(32'd1234));
        next_tbl = 64'h0000_0100_0000_0000;
        s_lo = 64'hF000_0110_0000_0000;
        s_hi = 64'h0000_0120_0000_0000;
        s_code = 0;
        set_mode(0);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !ack && !mem_rd_valid, "R9 reset state idle",
            {60'd0, busy, done, ack, mem_rd_valid}, 64'd0);
        chk(pa == 0 && !hit, "R8 reset outputs cleared", pa, 64'd0);

        // huge entry at the top level with global rewrite (R5)
        set_mode(0); s_code = 0;
        va = 64'h0000_0012_3456_7ABC;
        a = eaddr(s_lo & PAM, va, 39, 9, 0);
        mem[a] = 64'h0000_00AB_C000_0000 | 64'h7043;
        run_one(va, 1'b1);

        // masked-to-zero directory entry at level 4, bit 63 selects high root (R4, R1)
        set_mode(1); s_code = 2;
        va = 64'h8123_4567_89AB_CDEF;
        a = eaddr(s_hi & PAM, va, 48, 9, 2);
        mem[a] = 64'h8000_0000_0000_0FBF;
        run_one(va, 1'b0);

        // all directory widths zero, invalid leaf (R3, R6, R7)
        set_mode(3); s_code = 3;
        va = 64'h0000_0000_0055_5000;
        a = eaddr(s_lo & PAM, va, 12, 9, 3);
        mem[a] = 64'h0000_0000_1234_5002;
        run_one(va, 1'b1);

        for (int i = 0; i < 400; i++) begin
            int m;
            m = int'($urandom % 10);
            set_mode(m < 4 ? 0 : (m < 7 ? 1 : (m < 9 ? 2 : 3)));
            s_code = 2'($urandom);
            run_one({$urandom, $urandom}, ($urandom % 2) == 0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule